// File: doc/BRIEF.md
# Two-Section Configurable Ripple Counter

This block is a counter with four state bits split into two sections, and each section has its own count clock. The low section is one toggle bit (`qa`) that advances on `cka`. The high section is a three-bit counter (`qd`, `qc`, `qb`) that advances on `ckb`. A build-time parameter fixes the length of the high section's cycle: five states (decade build), six states (divide-by-twelve build) or eight states (binary build). Both count inputs are asynchronous to the system clock. Each one passes through a short synchronizer, and its section steps once for every falling edge that the synchronizer detects.

Two groups of request lines act as AND gates. The counter clears to zero only when every line in the clear group is high. In the decade build, the counter loads BCD nine only when every line in the nine group is high. Clear wins over nine, and both win over counting. The surrounding logic decides how the two sections are chained. If `qa` drives `ckb` and the count goes to `cka`, the whole counter runs through 10, 12 or 16 states. In the decade build, if `qd` drives `cka` and the count goes to `ckb`, `qa` becomes a symmetric divide-by-ten square wave.

Top module: `cfg_ripple_counter`

## Requirements
- R1: While `rst_n` is low, `qa`, `qb`, `qc` and `qd` are all 0.
- R2: Each section changes state only on the third system clock edge after its count input goes low (SYNC_STAGES+1 edges), unless clear or nine acts. On that edge `qa` inverts, or the high section steps. A rising edge or a steady level on a count input changes nothing.
- R3: In the decade build (VARIANT=0), {qd,qc,qb} read as a binary number step 0,1,2,3,4 and then return to 0.
- R4: In the divide-by-twelve build (VARIANT=1), {qd,qc,qb} step through 0,1,2,4,5,6 and then return to 0.
- R5: In the binary build (VARIANT=2), {qd,qc,qb} step from 0 to 7 and then wrap to 0.
- R6: When every bit of `zero_req` is high, all four outputs are 0 after the next system clock edge. If any bit is low, the group has no effect.
- R7: In the decade build, when every bit of `nine_req` is high, {qd,qc,qb,qa} = 1001 after the next system clock edge. If any bit is low, the group has no effect.
- R8: When both groups are fully asserted at once, the outputs clear to 0.
- R9: In the divide-by-twelve and binary builds, `nine_req` has no effect.
- R10: While either group is fully asserted, falling edges on the count inputs do not advance the count.
- R11: When `qa` drives `ckb`, each falling edge on `cka` advances {qd,qc,qb,qa}. The decade build steps 0 to 9. The divide-by-twelve build steps 0 to 13 but skips 6 and 7. The binary build steps 0 to 15.
- R12: In the decade build, when `qd` drives `cka` and the count goes to `ckb`, `qa` inverts once every five `ckb` falling edges. It is therefore high for five of every ten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every input |
| rst_n | input | 1 | Asynchronous active-low reset |
| cka | input | 1 | Count input of the toggle section |
| ckb | input | 1 | Count input of the three-bit section |
| zero_req | input | GATE_W | Clear group; acts when all bits are high |
| nine_req | input | GATE_W | Load-nine group; acts when all bits are high (decade build only) |
| qa | output | 1 | Toggle section output |
| qb | output | 1 | High section bit 0 |
| qc | output | 1 | High section bit 1 |
| qd | output | 1 | High section bit 2 |

## Verification
The clear and load-nine groups act on the first system clock edge after they are driven. The bench drives them one half period before an edge and reads the outputs at the next falling clock edge. A falling count input reaches its section on the third edge. The bench checks on both sides of that edge: the old value after two edges and the new value after three. In chained wirings a change has to pass through two sections before it shows, which takes six edges. Every chained pulse therefore holds its low phase for ten cycles before the outputs are compared.

// File: rtl/cfg_ripple_pkg.sv
package cfg_ripple_pkg;

   localparam int VAR_DECADE = 0;
   localparam int VAR_DOZEN  = 1;
   localparam int VAR_BINARY = 2;
   localparam int VAR_COUNT  = 3;

   // BCD nine split across the two sections
   localparam logic [2:0] HIGH_NINE = 3'b100;
   localparam logic       LOW_NINE  = 1'b1;

   // five-state cycle; unused codes fall back to zero
   function automatic logic [2:0] step_quinary(input logic [2:0] s);
      logic [2:0] n;
      case (s)
         3'd0:    n = 3'd1;
         3'd1:    n = 3'd2;
         3'd2:    n = 3'd3;
         3'd3:    n = 3'd4;
         default: n = 3'd0;
      endcase
      return n;
   endfunction

   // six-state cycle that skips codes 3 and 7 so bit 2 has even duty
   function automatic logic [2:0] step_senary(input logic [2:0] s);
      logic [2:0] n;
      case (s)
         3'd0:    n = 3'd1;
         3'd1:    n = 3'd2;
         3'd2:    n = 3'd4;
         3'd3:    n = 3'd4;
         3'd4:    n = 3'd5;
         3'd5:    n = 3'd6;
         default: n = 3'd0;
      endcase
      return n;
   endfunction

   function automatic logic [2:0] step_octal(input logic [2:0] s);
      return s + 3'd1;
   endfunction

endpackage

// File: rtl/crc_fall_sampler.sv
module crc_fall_sampler #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic fall
);

   logic [STAGES-1:0] sync_q;
   logic              hist_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= din;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[STAGES-2:0], din};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q <= 1'b0;
      else        hist_q <= sync_q[STAGES-1];
   end

   assign fall = hist_q & ~sync_q[STAGES-1];

endmodule

// File: rtl/crc_gate.sv
module crc_gate #(
   parameter int W      = 2,
   parameter bit ENABLE = 1'b1
) (
   input  logic [W-1:0] req,
   output logic         all_o
);

   assign all_o = ENABLE && (&req);

endmodule

// File: rtl/crc_div2_stage.sv
module crc_div2_stage #(
   parameter bit LOAD_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adv,
   input  logic clr,
   input  logic load,
   output logic q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= 1'b0;
      else if (clr)  q <= 1'b0;
      else if (load) q <= LOAD_VAL;
      else if (adv)  q <= ~q;
   end

endmodule

// File: rtl/crc_high_section.sv
module crc_high_section
   import cfg_ripple_pkg::*;
#(
   parameter int VARIANT = VAR_DECADE
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       adv,
   input  logic       clr,
   input  logic       load,
   output logic [2:0] q
);

   logic [2:0] nxt;

   generate
      if (VARIANT == VAR_DECADE) begin : g_quinary
         assign nxt = step_quinary(q);
      end else if (VARIANT == VAR_DOZEN) begin : g_senary
         assign nxt = step_senary(q);
      end else begin : g_octal
         assign nxt = step_octal(q);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= 3'd0;
      else if (clr)  q <= 3'd0;
      else if (load) q <= HIGH_NINE;
      else if (adv)  q <= nxt;
   end

endmodule

// File: rtl/cfg_ripple_counter.sv
module cfg_ripple_counter
   import cfg_ripple_pkg::*;
#(
   parameter int VARIANT     = VAR_DECADE,
   parameter int GATE_W      = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cka,
   input  logic              ckb,
   input  logic [GATE_W-1:0] zero_req,
   input  logic [GATE_W-1:0] nine_req,
   output logic              qa,
   output logic              qb,
   output logic              qc,
   output logic              qd
);

   localparam bit HAS_NINE = (VARIANT == VAR_DECADE);

   generate
      if (VARIANT < 0 || VARIANT >= VAR_COUNT) begin : g_bad_variant
         $error("cfg_ripple_counter: VARIANT out of range");
      end
      if (GATE_W < 1) begin : g_bad_gate
         $error("cfg_ripple_counter: GATE_W must be at least 1");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("cfg_ripple_counter: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic       cka_fall;
   logic       ckb_fall;
   logic       zero_all;
   logic       nine_all;
   logic [2:0] high_q;

   crc_fall_sampler #(.STAGES(SYNC_STAGES)) i_samp_a (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (cka),
      .fall (cka_fall)
   );

   crc_fall_sampler #(.STAGES(SYNC_STAGES)) i_samp_b (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (ckb),
      .fall (ckb_fall)
   );

   crc_gate #(.W(GATE_W), .ENABLE(1'b1)) i_gate_zero (
      .req  (zero_req),
      .all_o(zero_all)
   );

   crc_gate #(.W(GATE_W), .ENABLE(HAS_NINE)) i_gate_nine (
      .req  (nine_req),
      .all_o(nine_all)
   );

   crc_div2_stage #(.LOAD_VAL(LOW_NINE)) i_low (
      .clk  (clk),
      .rst_n(rst_n),
      .adv  (cka_fall),
      .clr  (zero_all),
      .load (nine_all),
      .q    (qa)
   );

   crc_high_section #(.VARIANT(VARIANT)) i_high (
      .clk  (clk),
      .rst_n(rst_n),
      .adv  (ckb_fall),
      .clr  (zero_all),
      .load (nine_all),
      .q    (high_q)
   );

   assign qb = high_q[0];
   assign qc = high_q[1];
   assign qd = high_q[2];

endmodule

// File: rtl/crc_checker.sv
module crc_checker
   import cfg_ripple_pkg::*;
#(
   parameter int VARIANT = VAR_DECADE,
   parameter int GATE_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [GATE_W-1:0] zero_req,
   input logic [GATE_W-1:0] nine_req,
   input logic              cka_fall,
   input logic              ckb_fall,
   input logic              qa,
   input logic              qb,
   input logic              qc,
   input logic              qd
);

   logic       zero_on;
   logic       nine_on;
   logic [2:0] high;

   assign zero_on = &zero_req;
   assign nine_on = (VARIANT == VAR_DECADE) && (&nine_req);
   assign high    = {qd, qc, qb};

   // R6 and R8: a full clear group wins over everything
   assert_zero_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      zero_on |=> ({qd, qc, qb, qa} == 4'b0000));

   assert_low_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cka_fall && !zero_on && !nine_on) |=> $stable(qa));

   assert_low_toggles_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cka_fall && !zero_on && !nine_on) |=> (qa != $past(qa)));

   assert_high_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ckb_fall && !zero_on && !nine_on) |=> $stable(high));

   generate
      if (VARIANT == VAR_DECADE) begin : g_dec
         assert_nine_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (nine_on && !zero_on) |=> ({qd, qc, qb, qa} == 4'b1001));
         assert_high_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
            high <= 3'd4);
      end else begin : g_no_nine
         // R9: a full nine group alone leaves the state where it was
         assert_nine_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (&nine_req && !zero_on && !cka_fall && !ckb_fall) |=> $stable({qd, qc, qb, qa}));
      end
      if (VARIANT == VAR_DOZEN) begin : g_dozen
         assert_high_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (high != 3'd3) && (high != 3'd7));
      end
      if (VARIANT == VAR_BINARY) begin : g_bin
         assert_high_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (ckb_fall && !zero_on) |=> (high == $past(high) + 3'd1));
      end
   endgenerate

endmodule

bind cfg_ripple_counter crc_checker #(.VARIANT(VARIANT), .GATE_W(GATE_W)) i_crc_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .zero_req(zero_req),
   .nine_req(nine_req),
   .cka_fall(cka_fall),
   .ckb_fall(ckb_fall),
   .qa      (qa),
   .qb      (qb),
   .qc      (qc),
   .qd      (qd)
);

// File: tb/test_cfg_ripple_counter.sv
module test_cfg_ripple_counter;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cka_drv = 1'b0;
   logic       ckb_drv = 1'b0;
   logic [1:0] zero_req = 2'b00;
   logic [1:0] nine_req = 2'b00;
   int         wmode = 0;   // 0 independent, 1 qa->ckb, 2 qd->cka
   int         checks = 0;
   int         failures = 0;
   bit         finished = 1'b0;

   always #5 clk = ~clk;

   // expected chained values after pulse k (index k-1): {decade, dozen, binary}
   localparam logic [11:0] CHAIN_VEC [16] = '{
      {4'd1, 4'd1,  4'd1},  {4'd2, 4'd2,  4'd2},  {4'd3, 4'd3,  4'd3},
      {4'd4, 4'd4,  4'd4},  {4'd5, 4'd5,  4'd5},  {4'd6, 4'd8,  4'd6},
      {4'd7, 4'd9,  4'd7},  {4'd8, 4'd10, 4'd8},  {4'd9, 4'd11, 4'd9},
      {4'd0, 4'd12, 4'd10}, {4'd1, 4'd13, 4'd11}, {4'd2, 4'd0,  4'd12},
      {4'd3, 4'd1,  4'd13}, {4'd4, 4'd2,  4'd14}, {4'd5, 4'd3,  4'd15},
      {4'd6, 4'd4,  4'd0}
   };
   localparam logic [2:0] SEQ6 [6] = '{3'd0, 3'd1, 3'd2, 3'd4, 3'd5, 3'd6};

   logic qa_d, qb_d, qc_d, qd_d, cka_d, ckb_d;
   logic qa_t, qb_t, qc_t, qd_t, cka_t, ckb_t;
   logic qa_b, qb_b, qc_b, qd_b, cka_b, ckb_b;

   assign cka_d = (wmode == 2) ? qd_d : cka_drv;
   assign ckb_d = (wmode == 1) ? qa_d : ckb_drv;
   assign cka_t = (wmode == 2) ? qd_t : cka_drv;
   assign ckb_t = (wmode == 1) ? qa_t : ckb_drv;
   assign cka_b = (wmode == 2) ? qd_b : cka_drv;
   assign ckb_b = (wmode == 1) ? qa_b : ckb_drv;

   cfg_ripple_counter #(.VARIANT(0)) i_cfg_ripple_counter (
      .clk(clk), .rst_n(rst_n), .cka(cka_d), .ckb(ckb_d),
      .zero_req(zero_req), .nine_req(nine_req),
      .qa(qa_d), .qb(qb_d), .qc(qc_d), .qd(qd_d));

   cfg_ripple_counter #(.VARIANT(1)) i_cfg_ripple_counter_dozen (
      .clk(clk), .rst_n(rst_n), .cka(cka_t), .ckb(ckb_t),
      .zero_req(zero_req), .nine_req(nine_req),
      .qa(qa_t), .qb(qb_t), .qc(qc_t), .qd(qd_t));

   cfg_ripple_counter #(.VARIANT(2)) i_cfg_ripple_counter_bin (
      .clk(clk), .rst_n(rst_n), .cka(cka_b), .ckb(ckb_b),
      .zero_req(zero_req), .nine_req(nine_req),
      .qa(qa_b), .qb(qb_b), .qc(qc_b), .qd(qd_b));

   function automatic logic [3:0] dec_q();
      return {qd_d, qc_d, qb_d, qa_d};
   endfunction
   function automatic logic [3:0] doz_q();
      return {qd_t, qc_t, qb_t, qa_t};
   endfunction
   function automatic logic [3:0] bin_q();
      return {qd_b, qc_b, qb_b, qa_b};
   endfunction

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic pulse_a(input int low_wait);
      cka_drv = 1'b1; step(4);
      cka_drv = 1'b0; step(low_wait);
   endtask

   task automatic pulse_b(input int low_wait);
      ckb_drv = 1'b1; step(4);
      ckb_drv = 1'b0; step(low_wait);
   endtask

   initial begin
      step(3);
      // R1: reset state
      check("R1 decade", dec_q(), 4'b0000);
      check("R1 dozen",  doz_q(), 4'b0000);
      check("R1 binary", bin_q(), 4'b0000);
      rst_n = 1'b1;
      step(2);

      // R2: rising edge ignored, fall lands on the third edge
      cka_drv = 1'b1; step(5);
      check("R2 rising cka", dec_q(), 4'b0000);
      cka_drv = 1'b0; step(2);
      check("R2 before third edge", dec_q(), 4'b0000);
      step(1);
      check("R2 third edge", dec_q(), 4'b0001);
      ckb_drv = 1'b1; step(5);
      check("R2 rising ckb", dec_q(), 4'b0001);
      ckb_drv = 1'b0; step(3);
      check("R3 first step", dec_q(), 4'b0011);

      // R3 R4 R5: independent high-section sequences
      for (int n = 2; n <= 9; n++) begin
         pulse_b(4);
         check("R3 decade seq", dec_q(), {3'(n % 5), 1'b1});
         check("R4 dozen seq",  doz_q(), {SEQ6[n % 6], 1'b1});
         check("R5 binary seq", bin_q(), {3'(n % 8), 1'b1});
      end

      // R6: partial clear has no effect, full clear acts in one edge
      zero_req = 2'b01; step(3);
      check("R6 partial clear", dec_q(), 4'b1001);
      zero_req = 2'b10; step(3);
      check("R6 partial clear", bin_q(), 4'b0011);
      zero_req = 2'b11; step(1);
      check("R6 full clear decade", dec_q(), 4'b0000);
      check("R6 full clear dozen",  doz_q(), 4'b0000);
      check("R6 full clear binary", bin_q(), 4'b0000);

      // R10: count edges ignored under clear
      pulse_a(6);
      check("R10 held clear", dec_q(), 4'b0000);
      pulse_b(6);
      check("R10 held clear", bin_q(), 4'b0000);

      // R11: chained full-length count, vector walk
      wmode = 1; step(2);
      zero_req = 2'b00; step(2);
      for (int k = 0; k < 16; k++) begin
         pulse_a(10);
         check("R11 chain decade", dec_q(), CHAIN_VEC[k][11:8]);
         check("R11 chain dozen",  doz_q(), CHAIN_VEC[k][7:4]);
         check("R11 chain binary", bin_q(), CHAIN_VEC[k][3:0]);
      end

      // R7: partial nine ignored, full nine loads 1001
      nine_req = 2'b01; step(3);
      check("R7 partial nine", dec_q(), 4'b0110);
      nine_req = 2'b11; step(1);
      check("R7 nine load", dec_q(), 4'b1001);
      check("R9 nine ignored dozen",  doz_q(), 4'b0100);
      check("R9 nine ignored binary", bin_q(), 4'b0000);
      pulse_a(10);
      check("R10 held nine", dec_q(), 4'b1001);
      check("R9 dozen counts", doz_q(), 4'b0101);
      check("R9 binary counts", bin_q(), 4'b0001);

      // R8: clear beats nine
      zero_req = 2'b11; step(1);
      check("R8 clear over nine", dec_q(), 4'b0000);
      nine_req = 2'b00; step(2);
      check("R8 after release", dec_q(), 4'b0000);

      // R12: swapped wiring gives a symmetric divide-by-ten on qa
      wmode = 2; step(2);
      zero_req = 2'b00; step(2);
      for (int k = 1; k <= 20; k++) begin
         pulse_b(10);
         check("R12 square wave", {3'b000, qa_d}, {3'b000, 1'((k / 5) % 2)});
      end

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule